// File: doc/BRIEF.md
# Dual-Tag Cache Directory with Alias Retagging

This block is the tag directory of a set-associative data cache in which every line carries two tags. The virtual tag, guarded by its own single validity bit, answers lookups coming from the core. The physical tag, guarded by a two-bit coherence state, answers inquiry (snoop) cycles arriving from the external bus. Data storage, bus cycles and address translation sit outside the block.

A core lookup presents a virtual address with a strobe. The translated physical address follows one cycle later. If the virtual tags miss, the physical tags of the same set are searched with the translated address. When that search hits, the line is an alias of one already held. The block then rewrites that line's virtual tag in place, so that no second copy of the physical line is ever allocated, and it suppresses the miss request for that lookup. When both searches miss, the block raises a miss request so that the surrounding logic can fill the line.

The surrounding logic writes whole ways with a fill command that sets both tags and the state. A single-cycle command discards every virtual tag at once, for example on an address-space switch. The physical tags survive that command, so snooping stays correct and modified lines are not lost.

Top module: `dtag_dir`

## Requirements
- R1: After reset every line is invalid: all result outputs are 0, and any lookup reports a miss request while any snoop reports no hit.
- R2: An accepted lookup strobe produces exactly one `lk_done` pulse two clock edges later. A snoop request produces `sn_done` two edges later. `lk_paddr` is sampled on the edge between them.
- R3: A lookup hits (`lk_hit`=1, `lk_way` = binary way number) only when the virtual tag matches, its validity bit is set and the line state is not I. State encoding: I=0, S=1, E=2, M=3.
- R4: When the virtual tags miss but the physical tag of a non-I line matches `lk_paddr`, the block reports `lk_retag`=1 with `lk_way` set to that way and `lk_hit`=0. It overwrites that line's virtual tag with the new one and sets its validity, and the coherence state is unchanged.
- R5: `miss_req` is asserted only when both the virtual and the physical search miss. At most one of `lk_hit`, `lk_retag`, `miss_req` is ever high, and only together with `lk_done`.
- R6: A snoop compares only physical tags. `sn_hit` means a non-I line matched, and `sn_hitm` means that line is in state M.
- R7: `inv_all` clears every virtual validity bit in one cycle and leaves physical tags and states untouched. A later lookup of a formerly hitting address then retags instead of hitting, and snoops are unaffected.
- R8: A lookup strobe arriving while an earlier lookup is still waiting for its physical phase is ignored and produces no result.
- R9: A fill writes the virtual tag, the physical tag and the state of the chosen way and set. A fill with state I removes the line from both lookups and snoops.
- R10: The set index is address bits [11:5] and the tag is bits [31:12] for both address kinds. Offset bits [4:0] do not affect matching, and an equal tag in another set does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address of the lookup, valid with the strobe |
| lk_paddr | input | 32 | Translated physical address, valid the cycle after the strobe |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Virtual tag hit |
| lk_retag | output | 1 | Virtual miss with physical hit; the virtual tag was rewritten |
| lk_way | output | 2 | Way of the hit or retagged line |
| miss_req | output | 1 | Both tag searches missed; a line fill is needed |
| sn_req | input | 1 | Snoop inquiry strobe |
| sn_paddr | input | 32 | Snoop physical address |
| sn_done | output | 1 | Snoop result valid |
| sn_hit | output | 1 | Snoop found a valid line |
| sn_hitm | output | 1 | Snoop found a modified line |
| inv_all | input | 1 | Clear all virtual validity bits |
| fill_we | input | 1 | Write one way of one set |
| fill_way | input | 2 | Way to write |
| fill_vaddr | input | 32 | Virtual address giving the set and virtual tag |
| fill_paddr | input | 32 | Physical address giving the physical tag |
| fill_state | input | 2 | Coherence state to store (I=0, S=1, E=2, M=3) |

## Verification
The hardest case to reach is the aliased line: a lookup whose virtual tag misses while its physical address names a line that is already present. The stimulus fills a line under one virtual tag. It then looks up a second virtual address in the same set with the same translated physical address, and it repeats the lookup to confirm that the line now hits under the new tag. It also checks that the old tag now retags in turn and that a snoop still sees the original state. The same path is reached a second way: a modified line is filled, the virtual tags are invalidated, and the line is looked up again.

// File: rtl/dtag_pkg.sv
package dtag_pkg;

  // Coherence state of a physical tag; the numeric codes are part of the interface.
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

endpackage

// File: rtl/dtag_way.sv
// Storage for one way: virtual and physical tag RAMs with registered reads,
// plus state and virtual-valid bits held in flops so they reset and clear at once.
module dtag_way #(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_rd,
  input  logic [IDX_W-1:0] core_idx,
  output logic [TAG_W-1:0] core_vtag_q,
  output logic [TAG_W-1:0] core_ptag_q,
  input  logic [IDX_W-1:0] core_st_idx,
  output logic [1:0]       core_st,
  output logic             core_vv,
  input  logic             snp_rd,
  input  logic [IDX_W-1:0] snp_idx,
  output logic [TAG_W-1:0] snp_ptag_q,
  input  logic [IDX_W-1:0] snp_st_idx,
  output logic [1:0]       snp_st,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_vtag,
  input  logic [TAG_W-1:0] fill_ptag,
  input  logic [1:0]       fill_st,
  input  logic             rt_we,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [TAG_W-1:0] rt_vtag,
  input  logic             inv_all
);
  import dtag_pkg::*;

  logic [TAG_W-1:0] vtag_mem [SETS];
  logic [TAG_W-1:0] ptag_mem [SETS];
  logic [1:0]       st_r     [SETS];
  logic [SETS-1:0]  vv_r;

  // A fill owns the virtual tag write port; a retag in the same cycle yields.
  logic             vt_we;
  logic [IDX_W-1:0] vt_idx;
  logic [TAG_W-1:0] vt_data;
  logic             rt_eff;

  assign rt_eff  = rt_we && !fill_we;
  assign vt_we   = fill_we || rt_eff;
  assign vt_idx  = fill_we ? fill_idx  : rt_idx;
  assign vt_data = fill_we ? fill_vtag : rt_vtag;

  always_ff @(posedge clk) begin
    if (vt_we) vtag_mem[vt_idx] <= vt_data;
    if (core_rd) core_vtag_q <= vtag_mem[core_idx];
  end

  always_ff @(posedge clk) begin
    if (fill_we) ptag_mem[fill_idx] <= fill_ptag;
    if (core_rd) core_ptag_q <= ptag_mem[core_idx];
    if (snp_rd)  snp_ptag_q  <= ptag_mem[snp_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) st_r[s] <= ST_I;
    end else if (fill_we) begin
      st_r[fill_idx] <= fill_st;
    end
  end

  // Later statements win: invalidate-all overrides a same-cycle set.
  always_ff @(posedge clk) begin
    if (rst) begin
      vv_r <= '0;
    end else begin
      if (fill_we) vv_r[fill_idx] <= (fill_st != ST_I);
      if (rt_eff)  vv_r[rt_idx]   <= 1'b1;
      if (inv_all) vv_r           <= '0;
    end
  end

  assign core_st = st_r[core_st_idx];
  assign core_vv = vv_r[core_st_idx];
  assign snp_st  = st_r[snp_st_idx];

endmodule

// File: rtl/dtag_match.sv
// Parallel tag compare across all ways with a lowest-way-first encoder.
module dtag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  input  logic [WAYS-1:0]            qual,
  output logic [WAYS-1:0]            hits,
  output logic                       any,
  output logic [WAY_W-1:0]           way
);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hits[g] = qual[g] && (tags[g] == key);
  end

  assign any = |hits;

  always_comb begin
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hits[w]) way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/dtag_dir.sv
// Dual-tag directory: virtual tags serve the core, physical tags serve snoops,
// and a virtual miss that hits physically retags the existing line.
module dtag_dir
  import dtag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_vaddr,
  input  logic [ADDR_W-1:0] lk_paddr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic              lk_retag,
  output logic [WAY_W-1:0]  lk_way,
  output logic              miss_req,
  input  logic              sn_req,
  input  logic [ADDR_W-1:0] sn_paddr,
  output logic              sn_done,
  output logic              sn_hit,
  output logic              sn_hitm,
  input  logic              inv_all,
  input  logic              fill_we,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [ADDR_W-1:0] fill_vaddr,
  input  logic [ADDR_W-1:0] fill_paddr,
  input  logic [1:0]        fill_state
);

  // ---------------- core lookup pipeline ----------------
  logic              s1_v;
  logic [ADDR_W-1:0] s1_vaddr;
  logic              accept;

  assign accept = lk_req && !s1_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) s1_vaddr <= lk_vaddr;
  end

  logic [IDX_W-1:0] rd_idx, s1_idx;
  logic [TAG_W-1:0] s1_vkey, s1_pkey;

  assign rd_idx  = lk_vaddr[OFF_W +: IDX_W];
  assign s1_idx  = s1_vaddr[OFF_W +: IDX_W];
  assign s1_vkey = s1_vaddr[ADDR_W-1 -: TAG_W];
  assign s1_pkey = lk_paddr[ADDR_W-1 -: TAG_W];

  // ---------------- snoop pipeline ----------------
  logic             sn_s1_v;
  logic [IDX_W-1:0] sn_s1_idx;
  logic [TAG_W-1:0] sn_s1_key;

  always_ff @(posedge clk) begin
    if (rst) begin
      sn_s1_v <= 1'b0;
    end else begin
      sn_s1_v <= sn_req;
    end
  end

  always_ff @(posedge clk) begin
    if (sn_req) begin
      sn_s1_idx <= sn_paddr[OFF_W +: IDX_W];
      sn_s1_key <= sn_paddr[ADDR_W-1 -: TAG_W];
    end
  end

  // ---------------- way storage ----------------
  logic [WAYS-1:0][TAG_W-1:0] way_vtag, way_ptag, way_sptag;
  logic [WAYS-1:0][1:0]       way_st, way_sst;
  logic [WAYS-1:0]            way_vv;
  logic [WAYS-1:0]            vqual, pqual, squal, s_mod;
  logic [WAYS-1:0]            vhits, phits, shits;
  logic                       vhit, phit, shit;
  logic [WAY_W-1:0]           vway, pway, sway;
  logic                       retag;

  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_vtag, fill_ptag;

  assign fill_idx  = fill_vaddr[OFF_W +: IDX_W];
  assign fill_vtag = fill_vaddr[ADDR_W-1 -: TAG_W];
  assign fill_ptag = fill_paddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_fill, wr_rt;
    assign wr_fill = fill_we && (fill_way == WAY_W'(w));
    assign wr_rt   = retag && (pway == WAY_W'(w));

    dtag_way #(
      .SETS  (SETS),
      .TAG_W (TAG_W)
    ) u_way (
      .clk         (clk),
      .rst         (rst),
      .core_rd     (accept),
      .core_idx    (rd_idx),
      .core_vtag_q (way_vtag[w]),
      .core_ptag_q (way_ptag[w]),
      .core_st_idx (s1_idx),
      .core_st     (way_st[w]),
      .core_vv     (way_vv[w]),
      .snp_rd      (sn_req),
      .snp_idx     (sn_paddr[OFF_W +: IDX_W]),
      .snp_ptag_q  (way_sptag[w]),
      .snp_st_idx  (sn_s1_idx),
      .snp_st      (way_sst[w]),
      .fill_we     (wr_fill),
      .fill_idx    (fill_idx),
      .fill_vtag   (fill_vtag),
      .fill_ptag   (fill_ptag),
      .fill_st     (fill_state),
      .rt_we       (wr_rt),
      .rt_idx      (s1_idx),
      .rt_vtag     (s1_vkey),
      .inv_all     (inv_all)
    );

    assign pqual[w] = (way_st[w] != ST_I);
    assign vqual[w] = way_vv[w] && pqual[w];
    assign squal[w] = (way_sst[w] != ST_I);
    assign s_mod[w] = (way_sst[w] == ST_M);
  end

  dtag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_vcmp (
    .tags (way_vtag), .key (s1_vkey), .qual (vqual),
    .hits (vhits), .any (vhit), .way (vway)
  );

  dtag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_pcmp (
    .tags (way_ptag), .key (s1_pkey), .qual (pqual),
    .hits (phits), .any (phit), .way (pway)
  );

  dtag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_scmp (
    .tags (way_sptag), .key (sn_s1_key), .qual (squal),
    .hits (shits), .any (shit), .way (sway)
  );

  // Physical hit on a virtual miss: rewrite the virtual tag, no miss request.
  assign retag = s1_v && !vhit && phit;

  // ---------------- registered results ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_retag <= 1'b0;
      lk_way   <= '0;
      miss_req <= 1'b0;
    end else begin
      lk_done  <= s1_v;
      lk_hit   <= s1_v && vhit;
      lk_retag <= retag;
      miss_req <= s1_v && !vhit && !phit;
      if (s1_v) lk_way <= vhit ? vway : (phit ? pway : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sn_done <= 1'b0;
      sn_hit  <= 1'b0;
      sn_hitm <= 1'b0;
    end else begin
      sn_done <= sn_s1_v;
      sn_hit  <= sn_s1_v && shit;
      sn_hitm <= sn_s1_v && shit && s_mod[sway];
    end
  end

endmodule

// File: rtl/dtag_dir_chk.sv
module dtag_dir_chk (
  input logic clk,
  input logic rst,
  input logic lk_req,
  input logic lk_done,
  input logic lk_hit,
  input logic lk_retag,
  input logic miss_req,
  input logic sn_req,
  input logic sn_done,
  input logic sn_hit,
  input logic sn_hitm
);

  AST_LK_DONE_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_done |-> $past(lk_req, 2)); // R2

  AST_SN_DONE_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    sn_done |-> $past(sn_req, 2)); // R2

  AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lk_hit, lk_retag, miss_req})); // R5

  AST_RESULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (lk_hit || lk_retag || miss_req) |-> lk_done); // R5

  AST_HITM_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    sn_hitm |-> sn_hit); // R6

  AST_SN_HIT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    sn_hit |-> sn_done); // R6

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    lk_done |=> !lk_done); // R8

endmodule

bind dtag_dir dtag_dir_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_req   (lk_req),
  .lk_done  (lk_done),
  .lk_hit   (lk_hit),
  .lk_retag (lk_retag),
  .miss_req (miss_req),
  .sn_req   (sn_req),
  .sn_done  (sn_done),
  .sn_hit   (sn_hit),
  .sn_hitm  (sn_hitm)
);

// File: tb/tb_dtag_dir.sv
module tb_dtag_dir;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0, lk_paddr = '0;
  logic        lk_done, lk_hit, lk_retag, miss_req;
  logic [1:0]  lk_way;
  logic        sn_req = 1'b0;
  logic [31:0] sn_paddr = '0;
  logic        sn_done, sn_hit, sn_hitm;
  logic        inv_all = 1'b0;
  logic        fill_we = 1'b0;
  logic [1:0]  fill_way = '0;
  logic [31:0] fill_vaddr = '0, fill_paddr = '0;
  logic [1:0]  fill_state = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dtag_dir dut (
    .clk (clk), .rst (rst),
    .lk_req (lk_req), .lk_vaddr (lk_vaddr), .lk_paddr (lk_paddr),
    .lk_done (lk_done), .lk_hit (lk_hit), .lk_retag (lk_retag),
    .lk_way (lk_way), .miss_req (miss_req),
    .sn_req (sn_req), .sn_paddr (sn_paddr),
    .sn_done (sn_done), .sn_hit (sn_hit), .sn_hitm (sn_hitm),
    .inv_all (inv_all),
    .fill_we (fill_we), .fill_way (fill_way), .fill_vaddr (fill_vaddr),
    .fill_paddr (fill_paddr), .fill_state (fill_state)
  );

  localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_E = 2'd2, S_M = 2'd3;

  function automatic logic [31:0] mk(input logic [19:0] tag, input logic [6:0] idx,
                                     input logic [4:0] off);
    return {tag, idx, off};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Strobe at a falling edge, physical address one cycle later, sample two cycles on.
  task automatic lookup(input logic [31:0] va, input logic [31:0] pa);
    @(negedge clk); lk_req = 1'b1; lk_vaddr = va;
    @(negedge clk); lk_req = 1'b0; lk_paddr = pa;
    @(negedge clk);
  endtask

  task automatic expect_lk(input string req, input logic [31:0] va, input logic [31:0] pa,
                           input logic h, input logic r, input logic m, input logic [1:0] w);
    lookup(va, pa);
    chk(req, "lk_done", lk_done, 1);
    chk(req, "lk_hit", lk_hit, h);
    chk(req, "lk_retag", lk_retag, r);
    chk(req, "miss_req", miss_req, m);
    if (h || r) chk(req, "lk_way", lk_way, w);
  endtask

  task automatic expect_sn(input string req, input logic [31:0] pa,
                           input logic h, input logic hm);
    @(negedge clk); sn_req = 1'b1; sn_paddr = pa;
    @(negedge clk); sn_req = 1'b0;
    @(negedge clk);
    chk(req, "sn_done", sn_done, 1);
    chk(req, "sn_hit", sn_hit, h);
    chk(req, "sn_hitm", sn_hitm, hm);
  endtask

  task automatic fill(input logic [1:0] w, input logic [31:0] va, input logic [31:0] pa,
                      input logic [1:0] st);
    @(negedge clk);
    fill_we = 1'b1; fill_way = w; fill_vaddr = va; fill_paddr = pa; fill_state = st;
    @(negedge clk); fill_we = 1'b0;
  endtask

  task automatic do_inval;
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
  endtask

  localparam logic [6:0]  SA = 7'h15, SB = 7'h42, SC = 7'h07;
  localparam logic [19:0] VA = 20'h12345, VB = 20'h0ABCD, PA = 20'h80001;
  localparam logic [19:0] VM = 20'h55555, PM = 20'h9F00F, VS = 20'h33333, PS = 20'hA0A0A;

  task automatic t_reset;
    chk("R1", "lk_done after reset", lk_done, 0);
    chk("R1", "miss_req after reset", miss_req, 0);
    chk("R1", "sn_hit after reset", sn_hit, 0);
    expect_lk("R1", mk(VA, SA, 0), mk(PA, SA, 0), 0, 0, 1, 0);
    expect_sn("R1", mk(PA, SA, 0), 0, 0);
  endtask

  task automatic t_latency;
    @(negedge clk); lk_req = 1'b1; lk_vaddr = mk(VA, SA, 0);
    @(negedge clk); lk_req = 1'b0; lk_paddr = mk(PA, SA, 0);
    chk("R2", "lk_done one cycle after strobe", lk_done, 0);
    @(negedge clk);
    chk("R2", "lk_done two cycles after strobe", lk_done, 1);
    @(negedge clk);
    chk("R2", "lk_done is a single pulse", lk_done, 0);
  endtask

  task automatic t_fill_hit;
    fill(2'd2, mk(VA, SA, 0), mk(PA, SA, 0), S_E);
    expect_lk("R3", mk(VA, SA, 0), mk(PA, SA, 0), 1, 0, 0, 2'd2);
    expect_lk("R9", mk(VA, SA, 5'h1C), mk(PA, SA, 5'h1C), 1, 0, 0, 2'd2);
    expect_sn("R6", mk(PA, SA, 5'h04), 1, 0);
    expect_sn("R6", mk(VA, SA, 0), 0, 0);  // virtual tag value on the snoop port must not match
  endtask

  task automatic t_alias;
    expect_lk("R4", mk(VB, SA, 0), mk(PA, SA, 0), 0, 1, 0, 2'd2);
    expect_lk("R4", mk(VB, SA, 0), mk(PA, SA, 0), 1, 0, 0, 2'd2);
    expect_lk("R4", mk(VA, SA, 0), mk(PA, SA, 0), 0, 1, 0, 2'd2);
    expect_sn("R4", mk(PA, SA, 0), 1, 0);   // state E kept, not M
    expect_lk("R5", mk(VB, SA, 0), mk(20'h7777, SA, 0), 0, 0, 1, 0);
  endtask

  task automatic t_inval;
    fill(2'd1, mk(VM, SB, 0), mk(PM, SB, 0), S_M);
    expect_sn("R6", mk(PM, SB, 0), 1, 1);
    expect_lk("R7", mk(VM, SB, 0), mk(PM, SB, 0), 1, 0, 0, 2'd1);
    do_inval();
    expect_sn("R7", mk(PM, SB, 0), 1, 1);
    expect_lk("R7", mk(VM, SB, 0), mk(PM, SB, 0), 0, 1, 0, 2'd1);
    expect_lk("R7", mk(VM, SB, 0), mk(PM, SB, 0), 1, 0, 0, 2'd1);
  endtask

  task automatic t_state_qual;
    fill(2'd0, mk(VS, SC, 0), mk(PS, SC, 0), S_S);
    expect_lk("R3", mk(VS, SC, 0), mk(PS, SC, 0), 1, 0, 0, 2'd0);
    expect_sn("R6", mk(PS, SC, 0), 1, 0);
    fill(2'd0, mk(VS, SC, 0), mk(PS, SC, 0), S_I);
    expect_lk("R9", mk(VS, SC, 0), mk(PS, SC, 0), 0, 0, 1, 0);
    expect_sn("R9", mk(PS, SC, 0), 0, 0);
  endtask

  task automatic t_geometry;
    expect_lk("R10", mk(VM, SC, 0), mk(PM, SC, 0), 0, 0, 1, 0);
    expect_sn("R10", mk(PM, SA, 0), 0, 0);
    expect_lk("R10", mk(VM, SB, 5'h1F), mk(PM, SB, 5'h11), 1, 0, 0, 2'd1);
  endtask

  task automatic t_busy;
    @(negedge clk); lk_req = 1'b1; lk_vaddr = mk(VM, SB, 0);
    @(negedge clk); lk_vaddr = mk(VS, SC, 0); lk_paddr = mk(PM, SB, 0);
    @(negedge clk); lk_req = 1'b0;
    chk("R8", "first lookup done", lk_done, 1);
    chk("R8", "first lookup result is its own hit", lk_hit, 1);
    @(negedge clk);
    chk("R8", "ignored strobe gives no result", lk_done, 0);
    @(negedge clk);
    chk("R8", "still no result for ignored strobe", lk_done, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_fill_hit();
    t_alias();
    t_inval();
    t_state_qual();
    t_geometry();
    t_busy();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule